// File: doc/BRIEF.md
# Multi-Context Lookup-Table Array

This block is a row of small programmable logic cells. Each cell computes a single-bit function of its own four data inputs by looking the answer up in a 16-bit configuration word. Every cell holds several such words, one per context, in a private store. One context selector is shared by the whole array and decides, on every clock, which of the stored words each cell consults. The array can therefore behave as one circuit on one cycle and as a completely different circuit on the next.

A configuration write port reaches any (cell, context) slot. Loading words into a context that is not currently selected has no effect on the running function, so the next personality can be prepared while the current one keeps working. A write into the selected context is allowed. The word that was stored before the write still decides the result computed on the edge of the write, and the new word is used from the following edge. Every cell output is registered.

Top module: `mctx_lut_array`

## Requirements
- R1: While `rst_n` is low, `lut_out` is all zeros. Reset clears every configuration word in every cell and context to zero, so after reset every cell outputs 0 for any input and any context until it is written.
- R2: On each rising edge, cell c loads into `lut_out[c]` bit k of its configuration word for context `ctx_id`. Here k is the unsigned value of that cell's input slice `lut_in[c*4 +: 4]`, and bit 0 of the word answers input 0.
- R3: Each cell uses only its own stored words and its own input slice. Different cells may hold different functions in the same context.
- R4: A change of `ctx_id` changes the selected function at the next rising edge. `lut_out` does not change before that edge. Alternating `ctx_id` on every cycle alternates the function on every cycle.
- R5: A write into a context other than the one presented on `ctx_id` leaves `lut_out` unchanged while the inputs and context stay the same. The new word takes effect once that context is selected.
- R6: If a write targets the selected context, the output captured on that same edge uses the old word. The written word decides the output from the next edge.
- R7: With `cfg_we` low, the values on `cfg_cell`, `cfg_ctx` and `cfg_data` change no stored word.
- R8: A write changes only the slot named by `cfg_cell` and `cfg_ctx`. The other cells, and the other contexts of the same cell, keep their words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lut_in | input | NUM_CELLS*LUT_INPUTS | Data inputs, one LUT_INPUTS-bit slice per cell, cell 0 in the low bits |
| ctx_id | input | CTX_W | Shared context selector |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cell | input | CELL_W | Cell addressed by the write |
| cfg_ctx | input | CTX_W | Context addressed by the write |
| cfg_data | input | 2**LUT_INPUTS | Configuration word to store |
| lut_out | output | NUM_CELLS | Registered cell outputs, bit c from cell c |

## Verification
The case that is hardest to reach from the ports is a write into the selected context on the very edge where that context is being evaluated. The old word must win on that edge and the new word on the next one. The bench reaches this case by holding the inputs and the context fixed so that the output is settled, then raising the write strobe for exactly one cycle, and sampling the output after that edge and again after the following edge. Background writes are handled in a similar way: the inputs stay frozen while every cell's inactive word is replaced, so any disturbance would appear as a change on an output that should be flat.

// File: rtl/mctx_pkg.sv
package mctx_pkg;

   // Width of an index that selects one of n items, at least one bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Number of bits in a lookup-table word for a given input count.
   function automatic int word_width(input int inputs);
      return 1 << inputs;
   endfunction

endpackage

// File: rtl/mctx_cfg_store.sv
module mctx_cfg_store #(
   parameter int NUM_CTX = 2,
   parameter int WORD_W  = 16,
   parameter int CTX_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTX_W-1:0]  wr_ctx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [CTX_W-1:0]  rd_ctx,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] words [NUM_CTX];

   for (genvar k = 0; k < NUM_CTX; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[k] <= '0;
         end else if (wr_en && (wr_ctx == CTX_W'(k))) begin
            words[k] <= wr_data;
         end
      end
   end

   // Read side: a context index with no slot reads as all zeros.
   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NUM_CTX; k++) begin
         if (rd_ctx == CTX_W'(k)) begin
            rd_word = words[k];
         end
      end
   end

endmodule

// File: rtl/mctx_lut_eval.sv
module mctx_lut_eval #(
   parameter int LUT_INPUTS = 4,
   parameter int WORD_W     = 16
) (
   input  logic [WORD_W-1:0]     word_i,
   input  logic [LUT_INPUTS-1:0] addr_i,
   output logic                  bit_o
);

   assign bit_o = word_i[addr_i];

endmodule

// File: rtl/mctx_cell.sv
module mctx_cell #(
   parameter int NUM_CTX    = 2,
   parameter int LUT_INPUTS = 4,
   parameter int WORD_W     = 16,
   parameter int CTX_W      = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LUT_INPUTS-1:0] data_i,
   input  logic [CTX_W-1:0]      ctx_i,
   input  logic                  wr_en_i,
   input  logic [CTX_W-1:0]      wr_ctx_i,
   input  logic [WORD_W-1:0]     wr_data_i,
   output logic                  q_o
);

   logic [WORD_W-1:0] cur_word;
   logic              lut_bit;

   mctx_cfg_store #(
      .NUM_CTX (NUM_CTX),
      .WORD_W  (WORD_W),
      .CTX_W   (CTX_W)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_ctx  (wr_ctx_i),
      .wr_data (wr_data_i),
      .rd_ctx  (ctx_i),
      .rd_word (cur_word)
   );

   mctx_lut_eval #(
      .LUT_INPUTS (LUT_INPUTS),
      .WORD_W     (WORD_W)
   ) eval_i (
      .word_i (cur_word),
      .addr_i (data_i),
      .bit_o  (lut_bit)
   );

   // The registered output samples the word as stored before this edge, so a
   // same-edge write into the selected context is seen one cycle later.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= 1'b0;
      end else begin
         q_o <= lut_bit;
      end
   end

endmodule

// File: rtl/mctx_lut_array.sv
module mctx_lut_array
   import mctx_pkg::*;
#(
   parameter int NUM_CELLS  = 4,
   parameter int NUM_CTX    = 2,
   parameter int LUT_INPUTS = 4,
   localparam int WORD_W    = word_width(LUT_INPUTS),
   localparam int CTX_W     = idx_width(NUM_CTX),
   localparam int CELL_W    = idx_width(NUM_CELLS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_CELLS*LUT_INPUTS-1:0] lut_in,
   input  logic [CTX_W-1:0]                ctx_id,
   input  logic                            cfg_we,
   input  logic [CELL_W-1:0]               cfg_cell,
   input  logic [CTX_W-1:0]                cfg_ctx,
   input  logic [WORD_W-1:0]               cfg_data,
   output logic [NUM_CELLS-1:0]            lut_out
);

   // Elaboration-time parameter checks.
   if (NUM_CELLS < 1) begin : g_bad_cells
      $error("mctx_lut_array: NUM_CELLS must be at least 1");
   end
   if (NUM_CTX < 1) begin : g_bad_ctx
      $error("mctx_lut_array: NUM_CTX must be at least 1");
   end
   if ((LUT_INPUTS < 1) || (LUT_INPUTS > 6)) begin : g_bad_inputs
      $error("mctx_lut_array: LUT_INPUTS must lie in 1..6");
   end

   for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
      logic cell_we;

      assign cell_we = cfg_we && (cfg_cell == CELL_W'(c));

      mctx_cell #(
         .NUM_CTX    (NUM_CTX),
         .LUT_INPUTS (LUT_INPUTS),
         .WORD_W     (WORD_W),
         .CTX_W      (CTX_W)
      ) cell_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .data_i    (lut_in[c*LUT_INPUTS +: LUT_INPUTS]),
         .ctx_i     (ctx_id),
         .wr_en_i   (cell_we),
         .wr_ctx_i  (cfg_ctx),
         .wr_data_i (cfg_data),
         .q_o       (lut_out[c])
      );
   end

endmodule

// File: rtl/mctx_lut_array_chk.sv
module mctx_lut_array_chk #(
   parameter int NUM_CELLS  = 4,
   parameter int LUT_INPUTS = 4,
   parameter int WORD_W     = 16,
   parameter int CTX_W      = 1,
   parameter int CELL_W     = 2
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_CELLS*LUT_INPUTS-1:0] lut_in,
   input logic [CTX_W-1:0]                ctx_id,
   input logic                            cfg_we,
   input logic [CELL_W-1:0]               cfg_cell,
   input logic [CTX_W-1:0]                cfg_ctx,
   input logic [WORD_W-1:0]               cfg_data,
   input logic [NUM_CELLS-1:0]            lut_out
);

   // Record of the write accepted on the previous edge.
   logic                 w_v;
   logic [CELL_W-1:0]    w_cell;
   logic [CTX_W-1:0]     w_ctx;
   logic [WORD_W-1:0]    w_data;
   logic [NUM_CELLS-1:0] w_mask;
   logic                 exp_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_v    <= 1'b0;
         w_cell <= '0;
         w_ctx  <= '0;
         w_data <= '0;
      end else begin
         w_v    <= cfg_we;
         w_cell <= cfg_cell;
         w_ctx  <= cfg_ctx;
         w_data <= cfg_data;
      end
   end

   always_comb begin
      w_mask  = '0;
      exp_bit = 1'b0;
      for (int c = 0; c < NUM_CELLS; c++) begin
         if (w_cell == CELL_W'(c)) begin
            w_mask[c] = 1'b1;
            exp_bit   = w_data[lut_in[c*LUT_INPUTS +: LUT_INPUTS]];
         end
      end
   end

   // R1: outputs held at zero during reset.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_zero_R1: assert (lut_out == '0);
      end
   end

   // R5: write into a context that is not selected, with no write on the
   // edge before and frozen inputs, leaves the output flat.
   assert_background_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_ctx != ctx_id) && $stable(lut_in) && $stable(ctx_id) && !w_v)
      |=> $stable(lut_out));

   // R6: same-edge write into the selected context still yields the old result.
   assert_conflict_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_ctx == ctx_id) && $stable(lut_in) && $stable(ctx_id) && !w_v)
      |=> $stable(lut_out));

   // R6: the word written on the previous edge decides the next result.
   assert_conflict_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (w_v && (w_ctx == ctx_id))
      |=> (((lut_out & $past(w_mask)) != '0) == $past(exp_bit)));

   // R8: a write can only move the output of the cell it names.
   assert_slot_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (w_v && $stable(lut_in) && $stable(ctx_id))
      |=> (((lut_out ^ $past(lut_out)) & ~$past(w_mask)) == '0));

endmodule

bind mctx_lut_array mctx_lut_array_chk #(
   .NUM_CELLS  (NUM_CELLS),
   .LUT_INPUTS (LUT_INPUTS),
   .WORD_W     (WORD_W),
   .CTX_W      (CTX_W),
   .CELL_W     (CELL_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .lut_in   (lut_in),
   .ctx_id   (ctx_id),
   .cfg_we   (cfg_we),
   .cfg_cell (cfg_cell),
   .cfg_ctx  (cfg_ctx),
   .cfg_data (cfg_data),
   .lut_out  (lut_out)
);

// File: tb/mctx_lut_array_tb_top.sv
module mctx_lut_array_tb_top;

   localparam int NC  = 4;
   localparam int NX  = 2;
   localparam int LI  = 4;
   localparam int CW  = 16;
   localparam int XW  = 1;
   localparam int CLW = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b1;
   logic [NC*LI-1:0] lut_in = '0;
   logic [XW-1:0]    ctx_id = '0;
   logic             cfg_we = 1'b0;
   logic [CLW-1:0]   cfg_cell = '0;
   logic [XW-1:0]    cfg_ctx = '0;
   logic [CW-1:0]    cfg_data = '0;
   logic [NC-1:0]    lut_out;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;
   logic [CW-1:0] model [NC][NX];

   always #2 clk = ~clk;   // 250 MHz

   mctx_lut_array #(.NUM_CELLS(NC), .NUM_CTX(NX), .LUT_INPUTS(LI)) dut_i (
      .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .ctx_id(ctx_id),
      .cfg_we(cfg_we), .cfg_cell(cfg_cell), .cfg_ctx(cfg_ctx),
      .cfg_data(cfg_data), .lut_out(lut_out)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [NC-1:0] exp);
      n_run++;
      if (lut_out !== exp) begin
         n_fail++;
         $display("FAIL %s: lut_out=%b expected %b", req, lut_out, exp);
      end
   endtask

   function automatic logic [NC-1:0] pred(input logic [LI-1:0] v, input int x);
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++) r[c] = model[c][x][v];
      return r;
   endfunction

   // Context 0: 2-bit adder slice (sum0, sum1, carry, equality).
   // Context 1: other functions (xor of a bits, parity, and, nor).
   // Input value bits: [0]=a0 [1]=b0 [2]=a1 [3]=b1.
   function automatic logic [CW-1:0] table_word(input int c, input int x);
      logic [CW-1:0] w;
      for (int a = 0; a < CW; a++) begin
         logic a0, b0, a1, b1, f;
         a0 = a[0]; b0 = a[1]; a1 = a[2]; b1 = a[3];
         if (x == 0) begin
            case (c)
               0:       f = a0 ^ b0;
               1:       f = a1 ^ b1 ^ (a0 & b0);
               2:       f = (a1 & b1) | ((a1 ^ b1) & a0 & b0);
               default: f = (a0 == b0) && (a1 == b1);
            endcase
         end else begin
            case (c)
               0:       f = a0 ^ a1;
               1:       f = a0 ^ b0 ^ a1 ^ b1;
               2:       f = a0 & b0 & a1 & b1;
               default: f = !(a0 | b0 | a1 | b1);
            endcase
         end
         w[a] = f;
      end
      return w;
   endfunction

   task automatic drive(input logic [LI-1:0] v);
      lut_in = {NC{v}};
   endtask

   task automatic cfg_write(input int c, input int x, input logic [CW-1:0] d);
      cfg_we = 1'b1; cfg_cell = CLW'(c); cfg_ctx = XW'(x); cfg_data = d;
      step();
      cfg_we = 1'b0;
      model[c][x] = d;
   endtask

   task automatic test_reset();
      #1 rst_n = 1'b0;
      repeat (4) step();
      check("R1 during reset", '0);
      rst_n = 1'b1;
      for (int x = 0; x < NX; x++) begin
         for (int v = 0; v < 16; v += 5) begin
            ctx_id = XW'(x);
            drive(LI'(v));
            step();
            check("R1 cleared store", '0);
         end
      end
      for (int c = 0; c < NC; c++)
         for (int x = 0; x < NX; x++) model[c][x] = '0;
   endtask

   task automatic test_eval();
      for (int c = 0; c < NC; c++)
         for (int x = 0; x < NX; x++) cfg_write(c, x, table_word(c, x));
      for (int x = 0; x < NX; x++) begin
         ctx_id = XW'(x);
         for (int v = 0; v < 16; v++) begin
            drive(LI'(v));
            step();
            check("R2 R3 lookup", pred(LI'(v), x));
         end
      end
   endtask

   task automatic test_toggle();
      drive(4'b1011);
      ctx_id = '0;
      step();
      check("R4 settle", pred(4'b1011, 0));
      for (int i = 1; i < 9; i++) begin
         ctx_id = XW'(i % 2);
         #0.5;
         check("R4 no change before edge", pred(4'b1011, (i + 1) % 2));
         step();
         check("R4 per-cycle switch", pred(4'b1011, i % 2));
      end
   endtask

   task automatic test_background();
      drive(4'b0110);
      ctx_id = '0;
      step();
      check("R5 settle", pred(4'b0110, 0));
      for (int c = 0; c < NC; c++) begin
         cfg_write(c, 1, ~table_word(c, 1));
         check("R5 background write", pred(4'b0110, 0));
      end
      step();
      check("R5 still quiet", pred(4'b0110, 0));
      ctx_id = 1'b1;
      step();
      check("R5 new words active", pred(4'b0110, 1));
   endtask

   task automatic test_slot();
      logic [NC-1:0] before0, before1;
      drive(4'b0011);
      before1 = pred(4'b0011, 1);
      cfg_write(2, 0, ~model[2][0]);
      before0 = pred(4'b0011, 0);
      ctx_id = '0;
      step();
      check("R8 only written cell moves", before0);
      ctx_id = 1'b1;
      step();
      check("R8 other context kept", before1);
   endtask

   task automatic test_conflict();
      logic [NC-1:0] old_v;
      drive(4'b0101);
      ctx_id = '0;
      step();
      old_v = pred(4'b0101, 0);
      check("R6 settle", old_v);
      cfg_we = 1'b1; cfg_cell = 2'd0; cfg_ctx = 1'b0; cfg_data = ~model[0][0];
      step();
      cfg_we = 1'b0;
      check("R6 old word on write edge", old_v);
      model[0][0] = cfg_data;
      step();
      check("R6 new word next edge", pred(4'b0101, 0));
   endtask

   task automatic test_we_low();
      cfg_we = 1'b0;
      for (int c = 0; c < NC; c++) begin
         cfg_cell = CLW'(c); cfg_ctx = XW'(c % 2); cfg_data = ~model[c][c % 2];
         step();
      end
      for (int x = 0; x < NX; x++) begin
         ctx_id = XW'(x);
         for (int v = 0; v < 16; v += 3) begin
            drive(LI'(v));
            step();
            check("R7 strobe low ignored", pred(LI'(v), x));
         end
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, cycles=%0d expected<=20000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_eval();
      test_toggle();
      test_background();
      test_slot();
      test_conflict();
      test_we_low();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule